// File: doc/BRIEF.md
# Memory Clock-Enable Power-State Sequencer

This block sits on the controller side of a DDR2-style memory interface and owns the clock-enable pin plus a small command path. It puts the memory into one of its low-power states and brings it back out. A power-down request lowers the clock-enable. The memory then goes to active power-down if any bank is open, or to precharge power-down if all banks are idle. A self-refresh request lowers the clock-enable together with a REFRESH command. The block holds each clock-enable level for a minimum number of clocks. It waits while the main scheduler reports an operation in flight. It forces a wake from power-down before the refresh deadline can expire.

After self-refresh exit the block stays in an exit-wait mode. Its command output stays NOP during this mode. It tells the scheduler when non-read commands are allowed again and when reads are allowed again. While the clock-enable is high outside that wait, the scheduler owns the command bus, and the block's command output is only meaningful on the edges it controls. A request that would pair self refresh with an open bank is refused. The refusal sets a sticky error flag and leaves the mode unchanged.

Top module: `ddr_cke_seq`

## Requirements
- R1: After reset, cke_o is 1, mode_o is 0 (run), cmd_o is 0 (NOP), read_ok_o and issue_ok_o are 1, and err_o is 0.
- R2: In run mode (mode 0), a pd_req_i with busy_i low and the hold time met lowers cke_o on the next cycle, with cmd_o NOP. mode_o becomes 1 (active power-down) if banks_open_i was 1, or 2 (precharge power-down) if it was 0.
- R3: In run mode, sr_req_i with banks_open_i low, busy_i low and the hold time met moves the block to mode 3 (self refresh). cke_o falls and cmd_o is 2 (REFRESH) for that first low cycle only. When both requests are present, sr_req_i wins.
- R4: While cke_o stays low, cmd_o is 1 (DESELECT), and pd_req_i and sr_req_i have no effect on mode_o.
- R5: In modes 1, 2 or 3, wake_req_i with the hold time met raises cke_o on the next cycle with cmd_o NOP. Modes 1 and 2 go to mode 0. Mode 3 goes to mode 4 (self-refresh exit wait).
- R6: Every cke_o level, once driven, is held for at least MIN_CKE cycles. A request that arrives earlier waits until the hold time has passed.
- R7: While busy_i is 1, no power-down or self-refresh entry takes place, and cke_o stays 1.
- R8: In mode 4, cmd_o is NOP and read_ok_o is 0. issue_ok_o is 0 for the first XSNR_CYC cycles after cke_o rises and 1 after that. After XSRD_CYC cycles in mode 4 the block returns to mode 0, and read_ok_o goes to 1.
- R9: If no wake arrives, power-down (mode 1 or 2) ends by itself after exactly PD_MAX_CYC cycles with cke_o low.
- R10: In run mode, sr_req_i together with banks_open_i set err_o on the next cycle. err_o then stays 1 until reset, and mode_o and cke_o do not change for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_req_i | input | 1 | Power-down request |
| sr_req_i | input | 1 | Self-refresh request |
| wake_req_i | input | 1 | Request to leave a low-power state |
| banks_open_i | input | 1 | At least one bank is open |
| busy_i | input | 1 | Scheduler has a read, write, mode load or precharge in flight |
| cke_o | output | 1 | Memory clock enable |
| cmd_o | output | 2 | Command: 0 NOP, 1 DESELECT, 2 REFRESH |
| read_ok_o | output | 1 | Reads may be issued |
| issue_ok_o | output | 1 | Non-read commands may be issued |
| mode_o | output | 3 | 0 run, 1 active power-down, 2 precharge power-down, 3 self refresh, 4 exit wait |
| err_o | output | 1 | Sticky flag for a refused illegal request |

## Verification
The bench builds the block with MIN_CKE 3, XSNR_CYC 4, XSRD_CYC 12 and PD_MAX_CYC 20. With these values the whole self-refresh exit window and the forced power-down wake both complete within a few dozen cycles. Random request traffic therefore crosses these boundaries many times. It also often hits the three-cycle hold limit in both directions. The bench finds the exact cycles where issue_ok_o and read_ok_o rise and where a power-down ends on its own deadline, and checks the block against them.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    MODE_RUN = 3'd0,
    MODE_APD = 3'd1,
    MODE_PPD = 3'd2,
    MODE_SR  = 3'd3,
    MODE_SRX = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    BUS_NOP = 2'd0,
    BUS_DES = 2'd1,
    BUS_REF = 2'd2
  } bus_cmd_e;
endpackage

// File: rtl/cke_hold_timer.sv
module cke_hold_timer #(
  parameter int MIN_CKE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ok_o
);
  localparam int W = $clog2(MIN_CKE + 1);
  localparam logic [W-1:0] LIMIT = W'(MIN_CKE);

  logic [W-1:0] cnt_q;

  // counts cycles the present cke level has been on the pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= LIMIT;
    else if (restart_i)    cnt_q <= W'(1);
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + W'(1);
  end

  assign ok_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/pd_deadline.sv
module pd_deadline #(
  parameter int PD_MAX_CYC = 7800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int W = $clog2(PD_MAX_CYC + 1);
  localparam logic [W-1:0] START = W'(PD_MAX_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= START;
    else if (load_i)                cnt_q <= START;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/srx_window.sv
module srx_window #(
  parameter int XSNR_CYC = 10,
  parameter int XSRD_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic issue_ok_o,
  output logic done_o
);
  localparam int W = $clog2(XSRD_CYC + 1);
  localparam logic [W-1:0] NSR = W'(XSNR_CYC);
  localparam logic [W-1:0] LAST = W'(XSRD_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i)            cnt_q <= '0;
    else if (run_i && !done_o)   cnt_q <= cnt_q + W'(1);
  end

  assign issue_ok_o = (cnt_q >= NSR);
  assign done_o     = (cnt_q == LAST);
endmodule

// File: rtl/ddr_cke_seq.sv
module ddr_cke_seq
  import pwrseq_pkg::*;
#(
  parameter int MIN_CKE    = 3,
  parameter int XSNR_CYC   = 10,
  parameter int XSRD_CYC   = 200,
  parameter int PD_MAX_CYC = 7800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       sr_req_i,
  input  logic       wake_req_i,
  input  logic       banks_open_i,
  input  logic       busy_i,
  output logic       cke_o,
  output logic [1:0] cmd_o,
  output logic       read_ok_o,
  output logic       issue_ok_o,
  output logic [2:0] mode_o,
  output logic       err_o
);
  mode_e    state_q, state_d;
  bus_cmd_e cmd_q, cmd_d;
  logic     err_q;
  logic     hold_ok, hold_restart;
  logic     pd_load, pd_expired, pd_run;
  logic     srx_clear, srx_issue_ok, srx_done, srx_run;
  logic     reject;

  cke_hold_timer #(.MIN_CKE(MIN_CKE)) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (hold_restart),
    .ok_o      (hold_ok)
  );

  pd_deadline #(.PD_MAX_CYC(PD_MAX_CYC)) i_deadline (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (pd_load),
    .run_i     (pd_run),
    .expired_o (pd_expired)
  );

  srx_window #(.XSNR_CYC(XSNR_CYC), .XSRD_CYC(XSRD_CYC)) i_srx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (srx_clear),
    .run_i      (srx_run),
    .issue_ok_o (srx_issue_ok),
    .done_o     (srx_done)
  );

  assign pd_run  = (state_q == MODE_APD) || (state_q == MODE_PPD);
  assign srx_run = (state_q == MODE_SRX);

  always_comb begin
    state_d      = state_q;
    cmd_d        = BUS_NOP;
    hold_restart = 1'b0;
    pd_load      = 1'b0;
    srx_clear    = 1'b0;
    reject       = 1'b0;
    unique case (state_q)
      MODE_RUN: begin
        if (sr_req_i && banks_open_i) begin
          reject = 1'b1;
        end else if ((sr_req_i || pd_req_i) && !busy_i && hold_ok) begin
          hold_restart = 1'b1;
          pd_load      = 1'b1;
          if (sr_req_i) begin
            state_d = MODE_SR;
            cmd_d   = BUS_REF;
          end else begin
            state_d = banks_open_i ? MODE_APD : MODE_PPD;
          end
        end
      end
      MODE_APD, MODE_PPD: begin
        if (hold_ok && (wake_req_i || pd_expired)) begin
          state_d      = MODE_RUN;
          hold_restart = 1'b1;
        end else begin
          cmd_d = BUS_DES;
        end
      end
      MODE_SR: begin
        if (hold_ok && wake_req_i) begin
          state_d      = MODE_SRX;
          hold_restart = 1'b1;
          srx_clear    = 1'b1;
        end else begin
          cmd_d = BUS_DES;
        end
      end
      MODE_SRX: begin
        if (srx_done) state_d = MODE_RUN;
      end
      default: state_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_RUN;
      cmd_q   <= BUS_NOP;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      if (reject) err_q <= 1'b1;
    end
  end

  assign cke_o      = (state_q == MODE_RUN) || (state_q == MODE_SRX);
  assign cmd_o      = cmd_q;
  assign mode_o     = state_q;
  assign err_o      = err_q;
  assign read_ok_o  = (state_q == MODE_RUN);
  assign issue_ok_o = (state_q == MODE_RUN) || ((state_q == MODE_SRX) && srx_issue_ok);
endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
  parameter int MIN_CKE = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       banks_open_i,
  input logic       cke_o,
  input logic [1:0] cmd_o,
  input logic       read_ok_o,
  input logic [2:0] mode_o,
  input logic       err_o
);
  localparam int W = $clog2(MIN_CKE + 1);
  localparam logic [W-1:0] LIMIT = W'(MIN_CKE);

  logic         prev_cke_q;
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cke_q <= 1'b1;
      held_q     <= LIMIT;
    end else begin
      prev_cke_q <= cke_o;
      if (cke_o != prev_cke_q) held_q <= W'(1);
      else if (held_q < LIMIT)  held_q <= held_q + W'(1);
    end
  end

  assert_min_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o != prev_cke_q) |-> (held_q >= LIMIT));

  assert_ref_only_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cke_o) && cmd_o == 2'd2) |-> $past(!banks_open_i));

  assert_no_entry_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> $past(!busy_i));

  assert_exit_nop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd_o == 2'd0));

  assert_low_deselect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && $past(!cke_o)) |-> (cmd_o == 2'd1));

  assert_srx_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> (!read_ok_o && cke_o));

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_o) |-> err_o);

  assert_apd_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 || mode_o == 3'd2) |-> !cke_o);
endmodule

bind ddr_cke_seq pwrseq_checker #(.MIN_CKE(MIN_CKE)) i_pwrseq_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .banks_open_i (banks_open_i),
  .cke_o        (cke_o),
  .cmd_o        (cmd_o),
  .read_ok_o    (read_ok_o),
  .mode_o       (mode_o),
  .err_o        (err_o)
);

// File: tb/test_ddr_cke_seq.sv
`timescale 1ns/1ps
module test_ddr_cke_seq;
  localparam int MIN_CKE = 3;
  localparam int XSNR    = 4;
  localparam int XSRD    = 12;
  localparam int PD_MAX  = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pd_req_i = 0, sr_req_i = 0, wake_req_i = 0, banks_open_i = 0, busy_i = 0;
  logic cke_o, read_ok_o, issue_ok_o, err_o;
  logic [1:0] cmd_o;
  logic [2:0] mode_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk_i = ~clk_i;

  ddr_cke_seq #(.MIN_CKE(MIN_CKE), .XSNR_CYC(XSNR), .XSRD_CYC(XSRD), .PD_MAX_CYC(PD_MAX)) i_ddr_cke_seq (
    .clk_i, .rst_ni, .pd_req_i, .sr_req_i, .wake_req_i, .banks_open_i, .busy_i,
    .cke_o, .cmd_o, .read_ok_o, .issue_ok_o, .mode_o, .err_o
  );

  // reference model, written from the requirements
  int m_mode, m_cmd, m_dwell, m_dl, m_srx;
  bit m_err;

  function automatic bit m_cke(int md);
    return (md == 0) || (md == 4);
  endfunction

  function automatic bit m_issue(int md, int sx);
    return (md == 0) || (md == 4 && sx >= XSNR);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_cmd = 0; m_dwell = MIN_CKE; m_dl = PD_MAX - 1; m_srx = 0; m_err = 0;
    end else begin
      int nd;
      nd = (m_dwell < MIN_CKE) ? m_dwell + 1 : m_dwell;
      case (m_mode)
        0: begin
          m_cmd = 0;
          if (sr_req_i && banks_open_i) m_err = 1;
          else if ((sr_req_i || pd_req_i) && !busy_i && m_dwell >= MIN_CKE) begin
            nd = 1; m_dl = PD_MAX - 1;
            if (sr_req_i) begin m_mode = 3; m_cmd = 2; end
            else m_mode = banks_open_i ? 1 : 2;
          end
        end
        1, 2: begin
          if (m_dwell >= MIN_CKE && (wake_req_i || m_dl == 0)) begin
            m_mode = 0; m_cmd = 0; nd = 1;
          end else begin
            m_cmd = 1; if (m_dl > 0) m_dl--;
          end
        end
        3: begin
          if (m_dwell >= MIN_CKE && wake_req_i) begin
            m_mode = 4; m_cmd = 0; nd = 1; m_srx = 0;
          end else m_cmd = 1;
        end
        default: begin
          m_cmd = 0;
          if (m_srx == XSRD - 1) m_mode = 0; else m_srx++;
        end
      endcase
      m_dwell = nd;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "mode_o", int'(mode_o), m_mode);
    chk(tag, "cke_o", int'(cke_o), int'(m_cke(m_mode)));
    chk(tag, "cmd_o", int'(cmd_o), m_cmd);
    chk(tag, "read_ok_o", int'(read_ok_o), int'(m_mode == 0));
    chk(tag, "issue_ok_o", int'(issue_ok_o), int'(m_issue(m_mode, m_srx)));
    chk(tag, "err_o", int'(err_o), int'(m_err));
  endtask

  task automatic step(string tag);
    @(posedge clk_i);
    @(negedge clk_i);
    cmp_all(tag);
  endtask

  task automatic idle_in();
    pd_req_i = 0; sr_req_i = 0; wake_req_i = 0;
  endtask

  initial begin
    int low_cnt;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset values
    chk("R1", "cke_o", int'(cke_o), 1);
    chk("R1", "mode_o", int'(mode_o), 0);
    chk("R1", "cmd_o", int'(cmd_o), 0);
    chk("R1", "read_ok_o", int'(read_ok_o), 1);
    chk("R1", "issue_ok_o", int'(issue_ok_o), 1);
    chk("R1", "err_o", int'(err_o), 0);

    // R7 busy blocks entry
    busy_i = 1; pd_req_i = 1;
    repeat (6) begin step("R7"); chk("R7", "cke held", int'(cke_o), 1); end
    busy_i = 0; banks_open_i = 1;
    step("R2");
    chk("R2", "active pd mode", int'(mode_o), 1);
    chk("R2", "entry nop", int'(cmd_o), 0);
    // R4 requests ignored while low, R6 wake waits for hold
    sr_req_i = 1; wake_req_i = 1;
    step("R4");
    chk("R6", "early wake held low", int'(cke_o), 0);
    step("R4");
    chk("R4", "deselect", int'(cmd_o), 1);
    step("R5");
    chk("R5", "exit rise", int'(cke_o), 1);
    chk("R5", "exit nop", int'(cmd_o), 0);
    idle_in(); banks_open_i = 0;

    // R3 self refresh with priority over pd
    step("R6"); step("R6");
    pd_req_i = 1; sr_req_i = 1;
    step("R3");
    chk("R3", "sr mode", int'(mode_o), 3);
    chk("R3", "refresh cmd", int'(cmd_o), 2);
    idle_in();
    step("R4");
    chk("R4", "refresh one cycle", int'(cmd_o), 1);
    step("R4"); step("R4");
    wake_req_i = 1;
    step("R5");
    chk("R5", "exit wait mode", int'(mode_o), 4);
    idle_in();
    for (int i = 0; i < XSRD + 2; i++) begin
      step("R8");
      if (i == XSNR - 2) chk("R8", "issue low", int'(issue_ok_o), 0);
      if (i == XSNR - 1) chk("R8", "issue high", int'(issue_ok_o), 1);
      if (i == XSRD - 2) chk("R8", "read low", int'(read_ok_o), 0);
      if (i == XSRD - 1) chk("R8", "read high", int'(read_ok_o), 1);
    end

    // R9 forced wake from precharge power-down
    pd_req_i = 1;
    step("R2");
    chk("R2", "precharge pd", int'(mode_o), 2);
    idle_in();
    low_cnt = 1;
    while (!cke_o && low_cnt < PD_MAX + 5) begin step("R9"); if (!cke_o) low_cnt++; end
    chk("R9", "low cycles", low_cnt, PD_MAX);

    // R10 self refresh with open bank refused
    banks_open_i = 1; sr_req_i = 1; pd_req_i = 1;
    step("R10");
    chk("R10", "err set", int'(err_o), 1);
    chk("R10", "mode kept", int'(mode_o), 0);
    idle_in();
    step("R10");
    chk("R10", "err sticky", int'(err_o), 1);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      pd_req_i     = ($urandom % 100) < 15;
      sr_req_i     = ($urandom % 100) < 8;
      wake_req_i   = ($urandom % 100) < 20;
      busy_i       = ($urandom % 100) < 30;
      if (($urandom % 100) < 10) banks_open_i = ~banks_open_i;
      step("R6");
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin @(posedge clk_i); cyc++; end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule